// File: doc/BRIEF.md
# Gated EPP Cycle Engine with Sticky Timeout

This block turns host register accesses into Enhanced Parallel Port address and data bus cycles. The host holds a request with an offset, a direction, a size and write data. The block answers with a one-cycle acknowledge that carries the read data. An access to the EPP address offset (3) or the EPP data offset (4) starts a bus cycle only if the control register holds the exact bit pattern for that direction. In every other case the access finishes at once and the peripheral sees nothing.

Each byte on the bus follows a handshake. The block drives the write line, then asserts the address or data strobe. It waits for the peripheral to raise its wait input, then releases the strobe. If wait stays low for `TMO_CYCLES` clocks, the block aborts the access and sets a sticky timeout flag. The host reads this flag in bit 0 of the status register and clears it by writing 1 to that bit. The data offset carries 1, 2 or 4 bytes, least significant byte first.

The sequencer walks through five named states:
- IDLE accepts a request. A gated EPP access goes to SETUP; any other access goes to FINISH.
- SETUP drives the bus for one cycle and moves to STROBE.
- STROBE holds the strobe. It goes to HOLD when wait is seen, or to FINISH on timeout.
- HOLD releases the strobe. It goes back to SETUP for the next byte, or to FINISH after the last byte.
- FINISH acknowledges and returns to IDLE.

Top module: `epp_gate`

## Requirements
- R1: After reset:
  - no strobe is asserted and the write line is high;
  - busy and acknowledge are low;
  - the control register reads 0xCC;
  - status bit 0 reads 0.
- R2: A write to offset 2 stores bits 5:0, which drive `pp_ctl_o`. A read of offset 2 returns those bits with bits 7:6 forced to 1.
- R3: A write to offset 3 or 4 runs a bus cycle only when control bits {5,3,2,1,0} equal exactly bit 2 set, all others clear (masked value 0x04). Bits 7:6 and bit 4 do not matter. Otherwise no strobe is asserted and the access is acknowledged with no effect.
- R4: A read of offset 3 or 4 runs a bus cycle only when the same masked control bits equal 0x24. Otherwise no strobe is asserted and the read returns 0xFFFFFFFF.
- R5: Each byte asserts exactly one strobe:
  - the write line is low for host writes and high for host reads;
  - offset 3 uses the address strobe and offset 4 the data strobe;
  - the byte completes when wait is high;
  - the strobe is released before the next byte.
- R6: On offset 4, size code 0, 1 and 2 moves 1, 2 and 4 bytes, least significant byte first. Read bytes are assembled little-endian and unfilled upper bytes read as ones. Offset 3 always moves one byte.
- R7: If wait does not go high within `TMO_CYCLES` clocks of a strobe:
  - the access aborts and the timeout flag is set;
  - the remaining bytes are skipped;
  - bytes not captured read as ones.
- R8: A read of offset 1 returns `pp_stat_i[7:1]` in bits 7:1 and the timeout flag in bit 0, whatever `pp_stat_i[0]` is. Bits 31:8 read as ones.
- R9: A write to offset 1 with bit 0 set clears the timeout flag. With bit 0 clear, the flag is left unchanged.
- R10: Busy is high from the cycle after acceptance until the acknowledge. The acknowledge lasts exactly one cycle.
- R11: Offsets other than 1 to 4 read 0xFFFFFFFF. Writes to them change no state and assert no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request, held until acknowledge |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_off | input | 3 | Register offset |
| host_size | input | 2 | Data size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| host_wdata | input | 32 | Write data |
| host_busy | output | 1 | Bus cycle in progress |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with acknowledge |
| pp_write_n | output | 1 | Bus write line, low for write bytes |
| pp_astb_n | output | 1 | Address strobe, active low |
| pp_dstb_n | output | 1 | Data strobe, active low |
| pp_data_o | output | 8 | Byte driven to the peripheral |
| pp_data_oe | output | 1 | Data output enable |
| pp_data_i | input | 8 | Byte from the peripheral |
| pp_wait | input | 1 | Peripheral completion handshake |
| pp_stat_i | input | 8 | Status lines from the port |
| pp_ctl_o | output | 6 | Stored control bits 5:0 |

## Verification
The assertions assume the host holds every request field steady until the acknowledge and drops the request in the cycle after it, so a new access can only be accepted in IDLE. They also assume wait is a clean synchronous level.

The bench drives every access through one task that does exactly this. Its peripheral model raises wait one cycle after a strobe and drops it after release, or never raises it when a timeout is being tested.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_FINISH
    } epp_state_e;

    localparam logic [2:0] OFF_STAT = 3'd1;
    localparam logic [2:0] OFF_CTL  = 3'd2;
    localparam logic [2:0] OFF_ADDR = 3'd3;
    localparam logic [2:0] OFF_DATA = 3'd4;

    // Control bits that decide whether a bus cycle may run.
    localparam logic [7:0] GATE_MASK = 8'h2F;
    localparam logic [7:0] GATE_WR   = 8'h04;
    localparam logic [7:0] GATE_RD   = 8'h24;

    localparam logic [5:0] CTL_RESET = 6'h0C;

endpackage

// File: rtl/epp_gate_regs.sv
module epp_gate_regs
    import epp_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    input  logic       tout_clr,
    input  logic       tout_set,
    output logic [7:0] ctl_q,
    output logic       tout_q
);

    logic [5:0] ctl_bits_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_bits_q <= CTL_RESET;
            tout_q     <= 1'b0;
        end else begin
            if (ctl_we) begin
                ctl_bits_q <= ctl_wdata[5:0];
            end
            if (tout_set) begin
                tout_q <= 1'b1;
            end else if (tout_clr) begin
                tout_q <= 1'b0;
            end
        end
    end

    assign ctl_q = {2'b11, ctl_bits_q};

    // R7: the sticky flag only rises after a timeout report.
    p_tout_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tout_q) |-> $past(tout_set));

    // R2: control holds its value unless written.
    p_ctl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable(ctl_q));

endmodule

// File: rtl/epp_gate_seq.sv
module epp_gate_seq
    import epp_gate_pkg::*;
#(
    parameter int TMO_CYCLES = 500,
    parameter int DW         = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic          host_wr,
    input  logic [2:0]    host_off,
    input  logic [1:0]    host_size,
    input  logic [DW-1:0] host_wdata,
    output logic          host_busy,
    output logic          host_ack,
    output logic [DW-1:0] host_rdata,
    input  logic [7:0]    ctl_i,
    input  logic          tout_i,
    input  logic [7:0]    stat_i,
    output logic          ctl_we,
    output logic [7:0]    ctl_wdata,
    output logic          tout_clr,
    output logic          tout_set,
    output logic          pp_write_n,
    output logic          pp_astb_n,
    output logic          pp_dstb_n,
    output logic [7:0]    pp_data_o,
    output logic          pp_data_oe,
    input  logic [7:0]    pp_data_i,
    input  logic          pp_wait
);

    localparam int NB = DW / 8;
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;
    localparam int CW = $clog2(TMO_CYCLES + 1);

    epp_state_e st_q, st_d;
    logic [2:0]    off_q;
    logic          wr_q;
    logic [IW-1:0] idx_q, last_q, size_last;
    logic [DW-1:0] wd_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic [7:0]    ctl_m;
    logic          is_epp, gate_ok, accept, timed_out, in_cyc, strobing;

    assign ctl_m     = ctl_i & GATE_MASK;
    assign is_epp    = (host_off == OFF_ADDR) || (host_off == OFF_DATA);
    assign gate_ok   = host_wr ? (ctl_m == GATE_WR) : (ctl_m == GATE_RD);
    assign accept    = (st_q == ST_IDLE) && host_req;
    assign timed_out = (st_q == ST_STROBE) && !pp_wait
                       && (cnt_q == CW'(TMO_CYCLES - 1));

    always_comb begin
        int span;
        span = 1 << host_size;
        if (span > NB) begin
            span = NB;
        end
        size_last = IW'(span - 1);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (host_req) st_d = (is_epp && gate_ok) ? ST_SETUP : ST_FINISH;
            ST_SETUP:  st_d = ST_STROBE;
            ST_STROBE: begin
                if (pp_wait)        st_d = ST_HOLD;
                else if (timed_out) st_d = ST_FINISH;
            end
            ST_HOLD:   st_d = (idx_q == last_q) ? ST_FINISH : ST_SETUP;
            ST_FINISH: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q  <= '0;
            wr_q   <= 1'b0;
            idx_q  <= '0;
            last_q <= '0;
            wd_q   <= '0;
            rd_q   <= '1;
            cnt_q  <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (host_req) begin
                    off_q  <= host_off;
                    wr_q   <= host_wr;
                    wd_q   <= host_wdata;
                    idx_q  <= '0;
                    cnt_q  <= '0;
                    last_q <= (host_off == OFF_DATA) ? size_last : '0;
                    rd_q   <= '1;
                    if (!host_wr && host_off == OFF_STAT) rd_q[7:0] <= {stat_i[7:1], tout_i};
                    if (!host_wr && host_off == OFF_CTL)  rd_q[7:0] <= ctl_i;
                end
                ST_SETUP:  cnt_q <= '0;
                ST_STROBE: begin
                    if (pp_wait) begin
                        if (!wr_q) rd_q[{idx_q, 3'b000} +: 8] <= pp_data_i;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_HOLD:   if (idx_q != last_q) idx_q <= idx_q + 1'b1;
                ST_FINISH: ;
                default:   ;
            endcase
        end
    end

    always_comb begin
        in_cyc     = (st_q == ST_SETUP) || (st_q == ST_STROBE) || (st_q == ST_HOLD);
        strobing   = (st_q == ST_STROBE);
        pp_write_n = !(in_cyc && wr_q);
        pp_data_oe = in_cyc && wr_q;
        pp_data_o  = wd_q[{idx_q, 3'b000} +: 8];
        pp_astb_n  = !(strobing && off_q == OFF_ADDR);
        pp_dstb_n  = !(strobing && off_q == OFF_DATA);
        host_busy  = in_cyc;
        host_ack   = (st_q == ST_FINISH);
        host_rdata = rd_q;
        ctl_we     = accept && host_wr && (host_off == OFF_CTL);
        ctl_wdata  = host_wdata[7:0];
        tout_clr   = accept && host_wr && (host_off == OFF_STAT) && host_wdata[0];
        tout_set   = timed_out;
    end

    // R5: never both strobes at once.
    p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!pp_astb_n && !pp_dstb_n));

    // R3: a write strobe only runs under the write pattern.
    p_gate_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pp_write_n && (!pp_astb_n || !pp_dstb_n)) |-> ((ctl_i & GATE_MASK) == GATE_WR));

    // R4: a read strobe only runs under the read pattern.
    p_gate_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pp_write_n && (!pp_astb_n || !pp_dstb_n)) |-> ((ctl_i & GATE_MASK) == GATE_RD));

    // R7: the wait counter never passes its limit while strobing.
    p_tmo_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STROBE) |-> (cnt_q < CW'(TMO_CYCLES)));

    // R7: a timeout ends the access at once.
    p_tmo_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tout_set |=> host_ack);

    // R10: acknowledge is a single-cycle pulse.
    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

endmodule

// File: rtl/epp_gate.sv
module epp_gate
    import epp_gate_pkg::*;
#(
    parameter int TMO_CYCLES = 500,
    parameter int DW         = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic          host_wr,
    input  logic [2:0]    host_off,
    input  logic [1:0]    host_size,
    input  logic [DW-1:0] host_wdata,
    output logic          host_busy,
    output logic          host_ack,
    output logic [DW-1:0] host_rdata,
    output logic          pp_write_n,
    output logic          pp_astb_n,
    output logic          pp_dstb_n,
    output logic [7:0]    pp_data_o,
    output logic          pp_data_oe,
    input  logic [7:0]    pp_data_i,
    input  logic          pp_wait,
    input  logic [7:0]    pp_stat_i,
    output logic [5:0]    pp_ctl_o
);

    logic [7:0] ctl_q, ctl_wdata;
    logic       tout_q, ctl_we, tout_clr, tout_set;

    epp_gate_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .tout_clr  (tout_clr),
        .tout_set  (tout_set),
        .ctl_q     (ctl_q),
        .tout_q    (tout_q)
    );

    epp_gate_seq #(.TMO_CYCLES(TMO_CYCLES), .DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_wr    (host_wr),
        .host_off   (host_off),
        .host_size  (host_size),
        .host_wdata (host_wdata),
        .host_busy  (host_busy),
        .host_ack   (host_ack),
        .host_rdata (host_rdata),
        .ctl_i      (ctl_q),
        .tout_i     (tout_q),
        .stat_i     (pp_stat_i),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .tout_clr   (tout_clr),
        .tout_set   (tout_set),
        .pp_write_n (pp_write_n),
        .pp_astb_n  (pp_astb_n),
        .pp_dstb_n  (pp_dstb_n),
        .pp_data_o  (pp_data_o),
        .pp_data_oe (pp_data_oe),
        .pp_data_i  (pp_data_i),
        .pp_wait    (pp_wait)
    );

    assign pp_ctl_o = ctl_q[5:0];

endmodule

// File: tb/epp_gate_test.sv
module epp_gate_test;

    localparam int TMO = 500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [2:0]  host_off = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic        host_busy, host_ack;
    logic [31:0] host_rdata;
    logic        pp_write_n, pp_astb_n, pp_dstb_n, pp_data_oe;
    logic [7:0]  pp_data_o, pp_data_i;
    logic        pp_wait;
    logic [7:0]  pp_stat_i = 8'h00;
    logic [5:0]  pp_ctl_o;

    int n_checks = 0, n_fail = 0, cycles = 0;

    // Peripheral model
    logic       wait_en = 1'b1;
    logic       wait_r = 1'b0;
    logic [7:0] rd_base = 8'h80, rd_cnt = 8'h00;
    int         nlog = 0;
    logic [9:0] logv [0:15];
    logic       busy_seen;

    always #10 clk = ~clk;

    epp_gate #(.TMO_CYCLES(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_off(host_off), .host_size(host_size), .host_wdata(host_wdata),
        .host_busy(host_busy), .host_ack(host_ack), .host_rdata(host_rdata),
        .pp_write_n(pp_write_n), .pp_astb_n(pp_astb_n), .pp_dstb_n(pp_dstb_n),
        .pp_data_o(pp_data_o), .pp_data_oe(pp_data_oe), .pp_data_i(pp_data_i),
        .pp_wait(pp_wait), .pp_stat_i(pp_stat_i), .pp_ctl_o(pp_ctl_o)
    );

    assign pp_wait   = wait_r;
    assign pp_data_i = rd_base + rd_cnt;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        wait_r <= wait_en && (!pp_astb_n || !pp_dstb_n);
        if (wait_en && (!pp_astb_n || !pp_dstb_n) && !wait_r) begin
            if (nlog < 16) logv[nlog] = {!pp_astb_n, pp_write_n, pp_data_o};
            nlog = nlog + 1;
        end
        if ((!pp_astb_n || !pp_dstb_n) && wait_r) rd_cnt <= rd_cnt + 1'b1;
    end

    always @(negedge clk) begin
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [2:0] off, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_off = off; host_size = sz; host_wdata = wd;
        cyc = 0; busy_seen = 1'b0;
        do begin
            @(negedge clk);
            cyc++;
            if (host_busy) busy_seen = 1'b1;
        end while (!host_ack && cyc < 5000);
        rd = host_rdata;
        host_req = 1'b0;
    endtask

    task automatic clear_log(input logic [7:0] base);
        nlog = 0; rd_base = base; rd_cnt = 8'h00;
    endtask

    task automatic t_reset();
        logic [31:0] rd; int c;
        check("R1 strobes idle", {29'd0, pp_astb_n, pp_dstb_n, pp_write_n}, 32'h7);
        check("R1 busy/ack low", {30'd0, host_busy, host_ack}, 32'h0);
        access(1'b0, 3'd2, 2'd0, 32'h0, rd, c);
        check("R1 control reset", rd, 32'hFFFFFFCC);
        access(1'b0, 3'd1, 2'd0, 32'h0, rd, c);
        check("R1 timeout clear", {31'd0, rd[0]}, 32'h0);
    endtask

    task automatic t_ctl();
        logic [31:0] rd; int c;
        access(1'b1, 3'd2, 2'd0, 32'h0000_003F, rd, c);
        access(1'b0, 3'd2, 2'd0, 32'h0, rd, c);
        check("R2 readback forced high", rd, 32'hFFFFFFFF);
        check("R2 control pins", {26'd0, pp_ctl_o}, 32'h3F);
        access(1'b1, 3'd2, 2'd0, 32'h0000_0001, rd, c);
        access(1'b0, 3'd2, 2'd0, 32'h0, rd, c);
        check("R2 readback low bits", rd, 32'hFFFFFFC1);
    endtask

    task automatic t_gate_write();
        logic [31:0] rd; int c;
        access(1'b1, 3'd2, 2'd0, 32'h0C, rd, c);
        clear_log(8'h80);
        access(1'b1, 3'd4, 2'd0, 32'hA5, rd, c);
        check("R3 blocked write no strobe", nlog, 0);
        access(1'b1, 3'd2, 2'd0, 32'hD4, rd, c);
        clear_log(8'h80);
        access(1'b1, 3'd3, 2'd0, 32'h5A, rd, c);
        check("R3 allowed write runs", nlog, 1);
        check("R5 address strobe write byte", {22'd0, logv[0]}, {22'd0, 2'b10, 8'h5A});
    endtask

    task automatic t_multi_write();
        logic [31:0] rd; int c;
        access(1'b1, 3'd2, 2'd0, 32'h04, rd, c);
        clear_log(8'h80);
        access(1'b1, 3'd4, 2'd2, 32'h11223344, rd, c);
        check("R6 four bytes", nlog, 4);
        check("R6 byte order", {logv[0][7:0], logv[1][7:0], logv[2][7:0], logv[3][7:0]}, 32'h44332211);
        check("R5 data strobe write line", {28'd0, logv[0][9:8], logv[3][9:8]}, {28'd0, 2'b00, 2'b00});
        check("R10 busy seen", {31'd0, busy_seen}, 32'h1);
        @(negedge clk);
        check("R10 ack single cycle", {31'd0, host_ack}, 32'h0);
        clear_log(8'h80);
        access(1'b1, 3'd4, 2'd1, 32'hCAFEBEEF, rd, c);
        check("R6 two bytes", {nlog[7:0], logv[0][7:0], logv[1][7:0]}, {8'd2, 8'hEF, 8'hBE});
    endtask

    task automatic t_reads();
        logic [31:0] rd; int c;
        clear_log(8'h80);
        access(1'b0, 3'd4, 2'd2, 32'h0, rd, c);
        check("R4 blocked read all ones", rd, 32'hFFFFFFFF);
        check("R4 blocked read no strobe", nlog, 0);
        access(1'b1, 3'd2, 2'd0, 32'h24, rd, c);
        clear_log(8'h80);
        access(1'b0, 3'd4, 2'd1, 32'h0, rd, c);
        check("R6 two-byte read", rd, 32'hFFFF8180);
        check("R5 read write line high", {30'd0, logv[0][9:8]}, 32'h1);
        clear_log(8'h40);
        access(1'b0, 3'd4, 2'd2, 32'h0, rd, c);
        check("R6 four-byte read", rd, 32'h43424140);
        clear_log(8'h20);
        access(1'b0, 3'd3, 2'd2, 32'h0, rd, c);
        check("R6 address read single byte", rd, 32'hFFFFFF20);
        check("R5 address strobe on read", {30'd0, logv[0][9:8]}, 32'h3);
    endtask

    task automatic t_timeout();
        logic [31:0] rd; int c;
        wait_en = 1'b0;
        pp_stat_i = 8'hA0;
        access(1'b1, 3'd2, 2'd0, 32'h04, rd, c);
        access(1'b1, 3'd4, 2'd2, 32'h01020304, rd, c);
        check("R7 abort skips bytes", {31'd0, (c >= TMO && c < TMO + 20)}, 32'h1);
        access(1'b0, 3'd1, 2'd0, 32'h0, rd, c);
        check("R8 status with flag", rd, 32'hFFFFFFA1);
        access(1'b1, 3'd2, 2'd0, 32'h24, rd, c);
        access(1'b0, 3'd4, 2'd2, 32'h0, rd, c);
        check("R7 timed-out read ones", rd, 32'hFFFFFFFF);
        wait_en = 1'b1;
        access(1'b1, 3'd1, 2'd0, 32'hFE, rd, c);
        access(1'b0, 3'd1, 2'd0, 32'h0, rd, c);
        check("R9 bit0 clear keeps flag", {31'd0, rd[0]}, 32'h1);
        access(1'b1, 3'd1, 2'd0, 32'h01, rd, c);
        pp_stat_i = 8'h5B;
        access(1'b0, 3'd1, 2'd0, 32'h0, rd, c);
        check("R9 R8 flag cleared overrides pin", rd, 32'hFFFFFF5A);
    endtask

    task automatic t_unused();
        logic [31:0] rd; int c;
        access(1'b1, 3'd2, 2'd0, 32'h24, rd, c);
        clear_log(8'h80);
        access(1'b1, 3'd0, 2'd0, 32'h00, rd, c);
        access(1'b1, 3'd5, 2'd0, 32'h00, rd, c);
        access(1'b0, 3'd2, 2'd0, 32'h0, rd, c);
        check("R11 writes leave control", rd, 32'hFFFFFFE4);
        access(1'b0, 3'd6, 2'd0, 32'h0, rd, c);
        check("R11 unused read ones", rd, 32'hFFFFFFFF);
        check("R11 no strobe", nlog, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctl();
        t_gate_write();
        t_multi_write();
        t_reads();
        t_timeout();
        t_unused();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule